// File: doc/BRIEF.md
# Row-Fed Tile Subswitch with Wormhole Output Locking

This block is one tile of a large router built as a grid of tiles. Each input port of a row drives a bus that reaches every tile in that row, so this tile sees one flit stream from each input of its row. Every stream enters a shallow local FIFO. Every output of the tile drives its own dedicated column channel toward one output port of the tile's column.

For each column output, a local arbiter chooses among the FIFOs whose front flit is a packet head addressed to that output. Selection is round-robin. The winning FIFO then owns the output until its tail flit has left, so packets cross the tile as wormhole traffic and never interleave on a column channel. Each output sends only while it holds a credit for the downstream column buffer. The far side returns one credit for each entry it frees.

All outputs arbitrate and transfer independently in the same cycle. When a FIFO is full, it drops its ready toward the row bus.

Top module: `tile_subswitch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every `col_valid` bit is 0 and every `row_ready` bit is 1. Each output starts with `CREDITS` credits and its round-robin pointer at input 0.
- R2: A flit is packed as {head[20], tail[19], dest[18:16], data[15:0]}. A head flit with dest = d goes out unchanged on column output d. If that output is free and holds a credit, the flit appears in the cycle after the edge that wrote it into its row FIFO.
- R3: Once an output has sent a head flit from input i, it sends only flits from input i until the flit marked tail has been sent. Packets from other inputs never interleave with it.
- R4: A free output picks from the inputs whose front flit is a head flit for it, searching upward from its pointer with wrap-around. When a packet's tail is sent, the pointer moves to the input after the winner.
- R5: An output sends nothing while its credit count is zero. Every flit it sends uses one credit.
- R6: Each one-cycle pulse on `col_credit[o]` adds one credit to output o, and that credit allows exactly one more flit.
- R7: `row_ready[i]` is 0 while FIFO i holds `BUF_DEPTH` flits. A flit offered while ready is 0 is discarded and never appears on any output.
- R8: Different outputs serve different inputs in the same cycle without affecting each other.
- R9: Flits from one input leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 8 | Per-input flit valid from the row buses |
| row_flit | input | 8*21 | Per-input flits; input i at bits [i*21 +: 21] |
| row_ready | output | 8 | Per-input FIFO not full |
| col_valid | output | 8 | Per-output flit valid on the column channel |
| col_flit | output | 8*21 | Per-output flits; output o at bits [o*21 +: 21] |
| col_credit | input | 8 | Per-output credit return, one credit per cycle high |

## Verification
The bench builds the tile with `BUF_DEPTH` = 2 and `CREDITS` = 2 and keeps the full 8 by 8 port count. With two FIFO entries, a three-flit packet already fills an input, so the ready drop and the discarding of an offered flit are reached after a few cycles. With two credits, an output runs dry partway through a packet, which shows the credit stall and the release of exactly one flit per returned credit. Contested heads on a shared output show wormhole locking, and a second round after the pointer has moved shows round-robin order that differs from fixed priority.

// File: rtl/tile_sw_pkg.sv
package tile_sw_pkg;

    localparam int PORTS  = 8;
    localparam int DATA_W = 16;
    localparam int DEST_W = $clog2(PORTS);
    localparam int IDX_W  = $clog2(PORTS);

    typedef struct packed {
        logic              head;
        logic              tail;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] data;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // first requester at or after ptr, wrapping
    function automatic pick_t rr_pick(input logic [PORTS-1:0] req,
                                      input logic [IDX_W-1:0] ptr);
        pick_t r;
        int    pos;
        r.found = 1'b0;
        r.idx   = '0;
        for (int k = PORTS - 1; k >= 0; k--) begin
            pos = int'(ptr) + k;
            if (pos >= PORTS) pos = pos - PORTS;
            if (req[pos]) begin
                r.found = 1'b1;
                r.idx   = IDX_W'(pos);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tile_row_fifo.sv
module tile_row_fifo
    import tile_sw_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_valid,
    input  flit_t push_flit,
    output logic  push_ready,
    input  logic  pop,
    output logic  front_valid,
    output flit_t front_flit
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    flit_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign push_ready  = (count != CNT_W'(DEPTH));
    assign front_valid = (count != '0);
    assign front_flit  = mem[rd_ptr];
    assign do_push     = push_valid && push_ready;
    assign do_pop      = pop && front_valid;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_flit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    AST_POP_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0)); // R9

    AST_FULL_DROPS_OFFER: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !push_ready && !pop) |=> (count == $past(count))); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R7

endmodule

// File: rtl/tile_col_port.sv
module tile_col_port
    import tile_sw_pkg::*;
#(
    parameter int CREDITS = 4,
    parameter int PORT_ID = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PORTS-1:0]       front_valid,
    input  flit_t [PORTS-1:0]      front_flit,
    input  logic                   credit_ret,
    output logic                   send,
    output logic [IDX_W-1:0]       sel,
    output logic                   out_valid,
    output flit_t                  out_flit
);
    localparam int CR_W = $clog2(CREDITS + 1);

    logic [CR_W-1:0]  credits;
    logic             locked;
    logic [IDX_W-1:0] owner;
    logic [IDX_W-1:0] rr_ptr;
    logic [PORTS-1:0] req;
    pick_t            pick;
    flit_t            cur;
    logic             has_credit;

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            req[i] = front_valid[i] && front_flit[i].head &&
                     (front_flit[i].dest == DEST_W'(PORT_ID));
        end
    end

    assign pick       = rr_pick(req, rr_ptr);
    assign has_credit = (credits != '0);

    always_comb begin
        if (locked) begin
            sel  = owner;
            send = front_valid[owner] && has_credit;
        end else begin
            sel  = pick.idx;
            send = pick.found && has_credit;
        end
        cur = front_flit[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
            locked    <= 1'b0;
            owner     <= '0;
            rr_ptr    <= '0;
        end else begin
            out_valid <= send;
            if (send) begin
                out_flit <= cur;
                if (cur.tail) begin
                    locked <= 1'b0;
                    rr_ptr <= (sel == IDX_W'(PORTS - 1)) ? '0 : sel + IDX_W'(1);
                end else begin
                    locked <= 1'b1;
                    owner  <= sel;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credits <= CR_W'(CREDITS);
        end else begin
            case ({send, credit_ret})
                2'b10:   credits <= credits - CR_W'(1);
                2'b01:   credits <= credits + CR_W'(1);
                default: credits <= credits;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        credits <= CR_W'(CREDITS)); // R6

    AST_DRY_NO_SEND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(credits) != '0)); // R5

    AST_PACKET_OPENS_ON_HEAD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(locked) || out_flit.head)); // R3

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(locked) && locked) |-> $stable(owner)); // R3

    AST_PTR_MOVES_ON_TAIL: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_flit.tail) |-> $stable(rr_ptr)); // R4

endmodule

// File: rtl/tile_subswitch.sv
module tile_subswitch
    import tile_sw_pkg::*;
#(
    parameter int BUF_DEPTH = 4,
    parameter int CREDITS   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PORTS-1:0]        row_valid,
    input  logic [PORTS*FLIT_W-1:0] row_flit,
    output logic [PORTS-1:0]        row_ready,
    output logic [PORTS-1:0]        col_valid,
    output logic [PORTS*FLIT_W-1:0] col_flit,
    input  logic [PORTS-1:0]        col_credit
);
    logic  [PORTS-1:0]             front_valid;
    flit_t [PORTS-1:0]             front_flit;
    logic  [PORTS-1:0]             pop;
    logic  [PORTS-1:0]             send;
    logic  [PORTS-1:0][IDX_W-1:0]  sel;
    logic  [PORTS-1:0][PORTS-1:0]  row_gnt;   // [input][output]

    for (genvar i = 0; i < PORTS; i++) begin : g_row
        flit_t in_f;
        assign in_f = flit_t'(row_flit[i*FLIT_W +: FLIT_W]);

        tile_row_fifo #(.DEPTH(BUF_DEPTH)) u_fifo (
            .clk         (clk),
            .rst         (rst),
            .push_valid  (row_valid[i]),
            .push_flit   (in_f),
            .push_ready  (row_ready[i]),
            .pop         (pop[i]),
            .front_valid (front_valid[i]),
            .front_flit  (front_flit[i])
        );
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_col
        flit_t out_f;

        tile_col_port #(.CREDITS(CREDITS), .PORT_ID(o)) u_port (
            .clk         (clk),
            .rst         (rst),
            .front_valid (front_valid),
            .front_flit  (front_flit),
            .credit_ret  (col_credit[o]),
            .send        (send[o]),
            .sel         (sel[o]),
            .out_valid   (col_valid[o]),
            .out_flit    (out_f)
        );

        assign col_flit[o*FLIT_W +: FLIT_W] = out_f;
    end

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            for (int o = 0; o < PORTS; o++) begin
                row_gnt[i][o] = send[o] && (sel[o] == IDX_W'(i));
            end
            pop[i] = |row_gnt[i];
        end
    end

    for (genvar i = 0; i < PORTS; i++) begin : g_chk
        AST_ONE_GRANT_PER_ROW: assert property (@(posedge clk) disable iff (rst)
            $onehot0(row_gnt[i])); // R3
    end

endmodule

// File: tb/tile_subswitch_tb.sv
`timescale 1ns/1ps
module tile_subswitch_tb_top;
    import tile_sw_pkg::*;

    localparam int BD = 2;
    localparam int CR = 2;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [PORTS-1:0]        row_valid = '0;
    logic [PORTS*FLIT_W-1:0] row_flit = '0;
    logic [PORTS-1:0]        row_ready;
    logic [PORTS-1:0]        col_valid;
    logic [PORTS*FLIT_W-1:0] col_flit;
    logic [PORTS-1:0]        col_credit;
    logic [PORTS-1:0]        auto_ret = '0;
    logic [PORTS-1:0]        man_ret = '0;
    logic                    auto_on = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] lg [PORTS][64];
    int          lt [PORTS][64];
    int          lc [PORTS];

    assign col_credit = auto_ret | man_ret;

    always #10 clk = ~clk;

    tile_subswitch #(.BUF_DEPTH(BD), .CREDITS(CR)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .row_valid  (row_valid),
        .row_flit   (row_flit),
        .row_ready  (row_ready),
        .col_valid  (col_valid),
        .col_flit   (col_flit),
        .col_credit (col_credit)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial for (int o = 0; o < PORTS; o++) lc[o] = 0;

    always @(negedge clk) begin
        for (int o = 0; o < PORTS; o++) begin
            if (col_valid[o] && lc[o] < 64) begin
                lg[o][lc[o]] = col_flit[o*FLIT_W +: 16];
                lt[o][lc[o]] = cyc;
                lc[o] = lc[o] + 1;
            end
            auto_ret[o] <= auto_on && col_valid[o];
        end
    end

    function automatic logic [FLIT_W-1:0] mk(input logic h, input logic t,
                                             input int d, input logic [15:0] dat);
        return {h, t, DEST_W'(d), dat};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lane(input int i, input logic [FLIT_W-1:0] f);
        row_valid[i] = 1'b1;
        row_flit[i*FLIT_W +: FLIT_W] = f;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(col_valid == '0, "R1 col_valid", col_valid, 0);
        chk(row_ready == '1, "R1 row_ready", row_ready, 8'hFF);
    endtask

    task automatic t_route;
        int b5, b1, tot0, c0;
        b5 = lc[5]; b1 = lc[1];
        tot0 = 0; for (int o = 0; o < PORTS; o++) tot0 += lc[o];
        @(negedge clk);
        c0 = cyc;
        lane(2, mk(1, 1, 5, 16'h2A01));
        lane(6, mk(1, 1, 1, 16'h6B02));
        @(negedge clk);
        row_valid = '0;
        idle(4);
        chk(lc[5] == b5 + 1, "R2 count out5", lc[5] - b5, 1);
        chk(lg[5][b5] == 16'h2A01, "R2 data out5", lg[5][b5], 16'h2A01);
        chk(lt[5][b5] == c0 + 2, "R2 latency", lt[5][b5], c0 + 2);
        chk(lg[1][b1] == 16'h6B02, "R8 data out1", lg[1][b1], 16'h6B02);
        chk(lt[1][b1] == lt[5][b5], "R8 same cycle", lt[1][b1], lt[5][b5]);
        begin
            int tot;
            tot = 0; for (int o = 0; o < PORTS; o++) tot += lc[o];
            chk(tot == tot0 + 2, "R2 no stray output", tot - tot0, 2);
        end
    endtask

    task automatic t_wormhole;
        int b;
        logic [15:0] exp [5];
        exp = '{16'h0000, 16'h0001, 16'h0002, 16'h1000, 16'h1001};
        b = lc[3];
        @(negedge clk);
        lane(0, mk(1, 0, 3, 16'h0000));
        lane(1, mk(1, 0, 3, 16'h1000));
        @(negedge clk);
        lane(0, mk(0, 0, 3, 16'h0001));
        lane(1, mk(0, 1, 3, 16'h1001));
        @(negedge clk);
        row_valid = '0;
        lane(0, mk(0, 1, 3, 16'h0002));
        @(negedge clk);
        row_valid = '0;
        idle(10);
        chk(lc[3] == b + 5, "R3 count out3", lc[3] - b, 5);
        for (int k = 0; k < 5; k++)
            chk(lg[3][b+k] == exp[k], "R3 R9 order out3", lg[3][b+k], exp[k]);
    endtask

    task automatic t_roundrobin;
        int b;
        b = lc[6];
        @(negedge clk);
        lane(2, mk(1, 1, 6, 16'h2200));
        lane(5, mk(1, 1, 6, 16'h5500));
        @(negedge clk);
        row_valid = '0;
        idle(5);
        chk(lg[6][b] == 16'h2200, "R4 round1 first", lg[6][b], 16'h2200);
        chk(lg[6][b+1] == 16'h5500, "R4 round1 second", lg[6][b+1], 16'h5500);
        lane(1, mk(1, 1, 6, 16'h1100));
        lane(6, mk(1, 1, 6, 16'h6600));
        @(negedge clk);
        row_valid = '0;
        idle(5);
        chk(lc[6] == b + 4, "R4 count out6", lc[6] - b, 4);
        chk(lg[6][b+2] == 16'h6600, "R4 round2 first", lg[6][b+2], 16'h6600);
        chk(lg[6][b+3] == 16'h1100, "R4 round2 second", lg[6][b+3], 16'h1100);
    endtask

    task automatic t_credits;
        int b;
        b = lc[7];
        @(negedge clk);
        lane(4, mk(1, 0, 7, 16'h4000));
        @(negedge clk);
        lane(4, mk(0, 0, 7, 16'h4001));
        @(negedge clk);
        lane(4, mk(0, 1, 7, 16'h4002));
        @(negedge clk);
        row_valid = '0;
        idle(6);
        chk(lc[7] == b + 2, "R5 stall at zero credit", lc[7] - b, 2);
        man_ret[7] = 1'b1;
        @(negedge clk);
        man_ret[7] = 1'b0;
        idle(4);
        chk(lc[7] == b + 3, "R6 one flit per credit", lc[7] - b, 3);
        chk(lg[7][b+2] == 16'h4002, "R6 released flit", lg[7][b+2], 16'h4002);
    endtask

    task automatic t_backpressure;
        int b;
        b = lc[7];
        @(negedge clk);
        lane(3, mk(1, 0, 7, 16'h3000));
        @(negedge clk);
        lane(3, mk(0, 1, 7, 16'h3001));
        @(negedge clk);
        row_valid = '0;
        chk(row_ready[3] == 1'b0, "R7 ready low when full", row_ready[3], 0);
        lane(3, mk(1, 1, 7, 16'hDEAD));
        @(negedge clk);
        row_valid = '0;
        chk(lc[7] == b, "R5 nothing sent while dry", lc[7] - b, 0);
        man_ret[7] = 1'b1;
        idle(2);
        man_ret[7] = 1'b0;
        idle(8);
        chk(lc[7] == b + 2, "R7 dropped flit absent", lc[7] - b, 2);
        chk(lg[7][b] == 16'h3000, "R7 first kept", lg[7][b], 16'h3000);
        chk(lg[7][b+1] == 16'h3001, "R7 second kept", lg[7][b+1], 16'h3001);
        chk(row_ready[3] == 1'b1, "R7 ready restored", row_ready[3], 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        auto_on = 1'b1;
        t_route();
        t_wormhole();
        t_roundrobin();
        auto_on = 1'b0;
        idle(3);
        t_credits();
        t_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end

endmodule